// File: doc/BRIEF.md
# Memory Address Window and Interleave Unit

This block sits between a processor-side address source and a memory bus. Each cycle it may receive a 24-bit physical address with a valid strobe. It decides whether the address belongs to the memory window owned by this unit and rearranges the address bits according to a 3-bit interleave mode. One cycle later it presents the reordered address, a hit flag, a miss flag and a flag for the reserved mode.

The window is set by two programmable bytes, a low byte and a high byte. Only the top address byte is compared against them, so the window always starts on a 64 KB boundary and ends on the last byte of a 64 KB block. The interleave modes take one, two or three of address bits 6, 7 and 8 and place them at the top of the outgoing address. The remaining bits keep their relative order below them. Software sets the low byte, the high byte and the mode through a small write port.

Top module: `addr_window_ilv`

## Requirements
- R1: After reset, out_valid, out_hit, out_miss and out_bad_mode are 0 and out_addr is 0. The low byte, the high byte and the mode are all 0, so the window is 0x000000 to 0x00FFFF and addresses pass through unchanged.
- R2: out_valid is 1 exactly in the cycle after a cycle in which in_valid was 1, and 0 otherwise.
- R3: For a valid input, out_hit is 1 when low <= in_addr[23:16] <= high and 0 otherwise. out_miss is the inverse of out_hit while out_valid is 1. Both flags are 0 while out_valid is 0.
- R4: When the low byte is greater than the high byte, no address is a hit. When the two bytes are equal, the window covers exactly {byte,16'h0000} to {byte,16'hFFFF}.
- R5: Mode 3'b000 passes in_addr to out_addr unchanged.
- R6: Mode 3'b001 gives {a[6],a[23:7],a[5:0]}. Mode 3'b010 gives {a[7],a[23:8],a[6:0]}. Mode 3'b011 gives {a[7:6],a[23:8],a[5:0]}.
- R7: Mode 3'b101 gives {a[8],a[6],a[23:9],a[7],a[5:0]}. Mode 3'b110 gives {a[8:7],a[23:9],a[6:0]}. Mode 3'b111 gives {a[8:6],a[23:9],a[5:0]}.
- R8: Mode 3'b100 is reserved. With it, a valid input sets out_bad_mode to 1 and passes the address unchanged, and the hit and miss flags are still computed. out_bad_mode is 0 for every other mode.
- R9: A write with cfg_we=1 updates a setting at the clock edge: cfg_sel 2'd0 sets the low byte, 2'd1 sets the high byte, and 2'd2 sets the mode from cfg_wdata[2:0]. cfg_sel 2'd3 changes nothing. An address presented in the same cycle as a write uses the old settings.
- R10: out_addr holds its value in cycles that follow a cycle without a valid input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select: 0 low byte, 1 high byte, 2 mode, 3 none |
| cfg_wdata | input | 8 | Setting write data |
| in_valid | input | 1 | Address valid |
| in_addr | input | 24 | Physical address from the processor side |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 24 | Reordered address for the memory bus |
| out_hit | output | 1 | Address was inside the window |
| out_miss | output | 1 | Address was outside the window |
| out_bad_mode | output | 1 | Reserved interleave mode was in force |

## Verification
The assertions assume that reset is held for at least one clock edge before the first valid input. They also assume that settings change only through the write port, so every past-cycle comparison refers to a configuration the bench has already set. The bench drives writes and addresses on the falling edge and checks results one edge later. It sweeps every mode over walking-one and mixed addresses, and sweeps all 256 upper bytes against normal, inverted and single-block windows. It also covers a write that coincides with an address and a write to the unused select.

// File: rtl/addr_ilv_pkg.sv
package addr_ilv_pkg;

    localparam int ADDR_W   = 24;
    localparam int WIN_W    = 8;
    localparam int MODE_W   = 3;
    localparam int SEL_W    = 2;
    localparam int ILV_BASE = 6;
    localparam int WIN_LSB  = ADDR_W - WIN_W;

    typedef enum logic [MODE_W-1:0] {
        ILV_NONE   = 3'b000,
        ILV_B6     = 3'b001,
        ILV_B7     = 3'b010,
        ILV_B76    = 3'b011,
        ILV_RSVD   = 3'b100,
        ILV_B86    = 3'b101,
        ILV_B87    = 3'b110,
        ILV_B876   = 3'b111
    } ilv_mode_e;

    typedef enum logic [SEL_W-1:0] {
        CSEL_LOW  = 2'd0,
        CSEL_HIGH = 2'd1,
        CSEL_MODE = 2'd2,
        CSEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [WIN_W-1:0] low;
        logic [WIN_W-1:0] high;
        ilv_mode_e        mode;
    } win_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              hit;
        logic              miss;
        logic              bad_mode;
    } win_result_t;

    // True when address bit idx is lifted to the top under mode m
    function automatic logic bit_lifted(input int idx, input logic [MODE_W-1:0] m);
        logic [MODE_W-1:0] sh;
        if (idx < ILV_BASE || idx >= ILV_BASE + MODE_W)
            return 1'b0;
        sh = m >> (idx - ILV_BASE);
        return sh[0];
    endfunction

    // Lifted bits go to the top (high to low), the rest follow in order
    function automatic logic [ADDR_W-1:0] ilv_reorder(input logic [ADDR_W-1:0] a,
                                                      input logic [MODE_W-1:0] m);
        logic [ADDR_W-1:0] r;
        int pos;
        r   = '0;
        pos = ADDR_W - 1;
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            if (bit_lifted(i, m)) begin
                r[pos] = a[i];
                pos    = pos - 1;
            end
        end
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            if (!bit_lifted(i, m)) begin
                r[pos] = a[i];
                pos    = pos - 1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
    import addr_ilv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [WIN_W-1:0] wdata,
    output win_cfg_t         cfg
);
    win_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.low  <= '0;
            cfg_q.high <= '0;
            cfg_q.mode <= ILV_NONE;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                CSEL_LOW:  cfg_q.low  <= wdata;
                CSEL_HIGH: cfg_q.high <= wdata;
                CSEL_MODE: cfg_q.mode <= ilv_mode_e'(wdata[MODE_W-1:0]);
                default:   ;
            endcase
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/win_range_cmp.sv
module win_range_cmp
    import addr_ilv_pkg::*;
(
    input  logic [WIN_W-1:0] upper,
    input  logic [WIN_W-1:0] low,
    input  logic [WIN_W-1:0] high,
    output logic             hit
);
    logic above_low;
    logic below_high;

    always_comb begin
        above_low  = (upper >= low);
        below_high = (upper <= high);
        hit        = above_low && below_high;
    end
endmodule

// File: rtl/ilv_bit_permute.sv
module ilv_bit_permute
    import addr_ilv_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_in,
    input  ilv_mode_e         mode,
    output logic [ADDR_W-1:0] addr_out,
    output logic              reserved
);
    logic [ADDR_W-1:0] perm [2**MODE_W];

    for (genvar m = 0; m < 2**MODE_W; m++) begin : g_mode
        if (m == int'(ILV_RSVD)) begin : g_rsvd
            assign perm[m] = addr_in;
        end else begin : g_legal
            assign perm[m] = ilv_reorder(addr_in, MODE_W'(m));
        end
    end

    assign addr_out = perm[mode];
    assign reserved = (mode == ILV_RSVD);
endmodule

// File: rtl/addr_window_ilv.sv
module addr_window_ilv
    import addr_ilv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WIN_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_hit,
    output logic              out_miss,
    output logic              out_bad_mode
);
    win_cfg_t          cfg;
    logic              win_hit;
    logic [ADDR_W-1:0] perm_addr;
    logic              perm_rsvd;
    win_result_t       res_q;

    win_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    win_range_cmp u_cmp (
        .upper (in_addr[ADDR_W-1:WIN_LSB]),
        .low   (cfg.low),
        .high  (cfg.high),
        .hit   (win_hit)
    );

    ilv_bit_permute u_perm (
        .addr_in  (in_addr),
        .mode     (cfg.mode),
        .addr_out (perm_addr),
        .reserved (perm_rsvd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid;
            if (in_valid) begin
                res_q.addr     <= perm_addr;
                res_q.hit      <= win_hit;
                res_q.miss     <= !win_hit;
                res_q.bad_mode <= perm_rsvd;
            end else begin
                res_q.hit      <= 1'b0;
                res_q.miss     <= 1'b0;
                res_q.bad_mode <= 1'b0;
            end
        end
    end

    assign out_valid    = res_q.valid;
    assign out_addr     = res_q.addr;
    assign out_hit      = res_q.hit;
    assign out_miss     = res_q.miss;
    assign out_bad_mode = res_q.bad_mode;
endmodule

// File: rtl/addr_window_ilv_chk.sv
module addr_window_ilv_chk
    import addr_ilv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_hit,
    input logic              out_miss,
    input logic              out_bad_mode,
    input logic [WIN_W-1:0]  cfg_low,
    input logic [WIN_W-1:0]  cfg_high,
    input logic [MODE_W-1:0] cfg_mode
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_hit != out_miss)); // R3
    AST_IDLE_FLAGS_LOW: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_hit && !out_miss && !out_bad_mode)); // R3
    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        in_valid && (cfg_low > cfg_high) |=> !out_hit); // R4
    AST_MODE0_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid && (cfg_mode == 3'b000) |=> (out_addr == $past(in_addr))); // R5
    AST_RSVD_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid && (cfg_mode == 3'b100) |=> out_bad_mode && (out_addr == $past(in_addr))); // R8
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_addr)); // R10
endmodule

bind addr_window_ilv addr_window_ilv_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_addr      (in_addr),
    .out_valid    (out_valid),
    .out_addr     (out_addr),
    .out_hit      (out_hit),
    .out_miss     (out_miss),
    .out_bad_mode (out_bad_mode),
    .cfg_low      (cfg.low),
    .cfg_high     (cfg.high),
    .cfg_mode     (cfg.mode)
);

// File: tb/addr_window_ilv_test.sv
module addr_window_ilv_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [7:0]  cfg_wdata;
    logic        in_valid;
    logic [23:0] in_addr;
    logic        out_valid;
    logic [23:0] out_addr;
    logic        out_hit;
    logic        out_miss;
    logic        out_bad_mode;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    addr_window_ilv uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_addr(out_addr), .out_hit(out_hit),
        .out_miss(out_miss), .out_bad_mode(out_bad_mode)
    );

    function automatic logic [23:0] exp_addr(input logic [23:0] a, input logic [2:0] m);
        case (m)
            3'b001:  return {a[6], a[23:7], a[5:0]};
            3'b010:  return {a[7], a[23:8], a[6:0]};
            3'b011:  return {a[7:6], a[23:8], a[5:0]};
            3'b101:  return {a[8], a[6], a[23:9], a[7], a[5:0]};
            3'b110:  return {a[8:7], a[23:9], a[6:0]};
            3'b111:  return {a[8:6], a[23:9], a[5:0]};
            default: return a;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [23:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic chk_out(input logic [23:0] a, input logic [2:0] m, input bit hit, input string req);
        check(out_valid == 1'b1, req, {31'd0, out_valid}, 32'd1);
        check(out_addr == exp_addr(a, m), req, {8'd0, out_addr}, {8'd0, exp_addr(a, m)});
        check(out_hit == hit && out_miss == !hit, req, {30'd0, out_hit, out_miss}, {30'd0, hit, !hit});
        check(out_bad_mode == (m == 3'b100), req, {31'd0, out_bad_mode}, {31'd0, m == 3'b100});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] a;
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'd0;
        in_valid = 1'b0; in_addr = 24'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        check({out_valid, out_hit, out_miss, out_bad_mode} == 4'b0, "R1 flags",
              {28'd0, out_valid, out_hit, out_miss, out_bad_mode}, 32'd0);
        check(out_addr == 24'd0, "R1 addr", {8'd0, out_addr}, 32'd0);
        // R1 default window 0x00xxxx, default mode passes through
        send(24'h00ABCD); chk_out(24'h00ABCD, 3'b000, 1'b1, "R1 default hit");
        send(24'h010000); chk_out(24'h010000, 3'b000, 1'b0, "R1 default miss");
        // R10 hold and R2 no valid
        @(negedge clk);
        check(out_valid == 1'b0, "R2 idle", {31'd0, out_valid}, 32'd0);
        check(out_addr == 24'h010000, "R10 hold", {8'd0, out_addr}, 32'h010000);
        check(!out_hit && !out_miss, "R3 idle flags", {30'd0, out_hit, out_miss}, 32'd0);

        // R5 R6 R7 R8 mode sweep with full window
        wr(2'd0, 8'h00); wr(2'd1, 8'hFF);
        for (int m = 0; m < 8; m++) begin
            wr(2'd2, 8'(m));
            for (int b = 0; b < 24; b++) begin
                a = 24'd1 << b;
                send(a); chk_out(a, 3'(m), 1'b1, m == 4 ? "R8 walk" : (m < 4 ? "R6 walk" : "R7 walk"));
            end
            send(24'hA5C39E); chk_out(24'hA5C39E, 3'(m), 1'b1, "R5 R6 R7 mixed");
            send(24'h5A3C61); chk_out(24'h5A3C61, 3'(m), 1'b1, "R5 R6 R7 mixed2");
        end

        // R3 window sweep with low 0x40 high 0x43
        wr(2'd2, 8'h00); wr(2'd0, 8'h40); wr(2'd1, 8'h43);
        for (int u = 0; u < 256; u++) begin
            a = {8'(u), 16'h1234};
            send(a); chk_out(a, 3'b000, (u >= 8'h40 && u <= 8'h43), "R3 sweep");
        end
        // R8 reserved mode keeps hit computation
        wr(2'd2, 8'h04);
        send(24'h41FFFF); chk_out(24'h41FFFF, 3'b100, 1'b1, "R8 hit");
        send(24'h44FFFF); chk_out(24'h44FFFF, 3'b100, 1'b0, "R8 miss");
        wr(2'd2, 8'h00);

        // R4 inverted window
        wr(2'd0, 8'h80); wr(2'd1, 8'h10);
        for (int u = 0; u < 256; u++) begin
            a = {8'(u), 16'h00FF};
            send(a); chk_out(a, 3'b000, 1'b0, "R4 inverted");
        end
        // R4 single block
        wr(2'd0, 8'h55); wr(2'd1, 8'h55);
        send(24'h550000); chk_out(24'h550000, 3'b000, 1'b1, "R4 block start");
        send(24'h55FFFF); chk_out(24'h55FFFF, 3'b000, 1'b1, "R4 block end");
        send(24'h54FFFF); chk_out(24'h54FFFF, 3'b000, 1'b0, "R4 below");
        send(24'h560000); chk_out(24'h560000, 3'b000, 1'b0, "R4 above");

        // R9 unused select changes nothing
        @(negedge clk); cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'hFF;
        @(negedge clk); cfg_we = 1'b0;
        send(24'h55F00F); chk_out(24'h55F00F, 3'b000, 1'b1, "R9 sel3 window");
        send(24'h56F00F); chk_out(24'h56F00F, 3'b000, 1'b0, "R9 sel3 window2");
        // R9 write in the same cycle as an address uses old settings
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h07;
        in_valid = 1'b1; in_addr = 24'h5501C0;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        chk_out(24'h5501C0, 3'b000, 1'b1, "R9 same cycle");
        send(24'h5501C0); chk_out(24'h5501C0, 3'b111, 1'b1, "R9 new mode");
        // R9 write to low byte takes effect next address
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h56;
        in_valid = 1'b1; in_addr = 24'h550000;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        chk_out(24'h550000, 3'b111, 1'b1, "R9 old low");
        send(24'h550000); chk_out(24'h550000, 3'b111, 1'b0, "R9 new low");

        // R2 back-to-back valids
        @(negedge clk); in_valid = 1'b1; in_addr = 24'h000040;
        @(negedge clk); in_addr = 24'h000080;
        check(out_valid == 1'b1, "R2 burst1", {31'd0, out_valid}, 32'd1);
        @(negedge clk); in_valid = 1'b0;
        check(out_valid == 1'b1 && out_addr == exp_addr(24'h000080, 3'b111), "R2 burst2",
              {8'd0, out_addr}, {8'd0, exp_addr(24'h000080, 3'b111)});
        @(negedge clk);
        check(out_valid == 1'b0, "R2 burst end", {31'd0, out_valid}, 32'd0);

        // R1 reset again clears outputs
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check(out_valid == 1'b0 && out_addr == 24'd0, "R1 rereset", {8'd0, out_addr}, 32'd0);
        send(24'h00FFFF); chk_out(24'h00FFFF, 3'b000, 1'b1, "R1 rereset cfg");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule